// File: doc/BRIEF.md
# Thread Doorbell Summary Register

This block holds the pending-doorbell flag of every hardware thread in a small multithreaded core and presents them as one shared register. A read gathers the flags of all sibling threads into a single word, with bit n belonging to thread n. A write sets or clears each thread's flag from the value bit at that thread's index. A separate per-thread send pulse sets a flag directly, which is how one thread rings another's doorbell.

A mode input selects single-thread partition behaviour. In that mode the register shrinks to one bit: a read returns only the accessing thread's own flag in bit 0, and a write changes only that thread's flag, using bit 0. Every access passes a hypervisor facility check first. A refused access raises a facility-unavailable exception pulse and a strobe that clears the interrupt-cause field of the hypervisor facility control register. The exception is not raised when the access runs in hypervisor state, when the core has no hypervisor mode, or when the enable bit is set.

Top module: `dbell_summary`

## Requirements
- R1: In shared mode, an accepted read at clock edge k drives `rd_valid` high and `rd_data` bit n equal to thread n's pending flag as it was just before edge k, in the cycle after edge k.
- R2: In shared mode, an accepted write at edge k loads every thread's pending flag n from `acc_wdata` bit n, so a 0 bit clears a pending doorbell.
- R3: Value bits at index NTHR and above are ignored on a write, and they always read as 0.
- R4: In single-thread mode, an accepted read returns the flag of thread `local_tid` in bit 0, and all other bits are 0.
- R5: In single-thread mode, an accepted write loads only the flag of thread `local_tid` from `acc_wdata` bit 0. All other flags are left unchanged.
- R6: An access is refused when `in_hv` is 0, `hv_present` is 1 and `fac_en` is 0. A refused access gives a one-cycle `fac_fault` pulse in the cycle after the access. An accepted access never produces the pulse.
- R7: A refused access writes no flag. A refused read gives `rd_valid` 0 and `rd_data` 0.
- R8: `cause_clr` pulses in the same cycle as every `fac_fault` pulse, and only then.
- R9: A `send_pulse` bit sets that thread's flag at the next edge. If an accepted write reaches the same thread in the same cycle, the written value takes priority.
- R10: After synchronous reset every flag is 0, and `rd_data`, `rd_valid`, `fac_fault` and `cause_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | DW | Write value |
| in_hv | input | 1 | Access runs in hypervisor state |
| hv_present | input | 1 | Core supports hypervisor mode |
| fac_en | input | 1 | Hypervisor facility-enable bit for this register |
| solo_mode | input | 1 | Single-thread partition mode |
| local_tid | input | TIDW | Index of the accessing thread |
| send_pulse | input | NTHR | Per-thread doorbell set pulses |
| pend | output | NTHR | Pending-doorbell flags, one per thread |
| rd_data | output | DW | Read result, registered |
| rd_valid | output | 1 | Read result valid |
| fac_fault | output | 1 | Facility-unavailable exception pulse |
| cause_clr | output | 1 | Clear strobe for the facility interrupt-cause field |

## Verification
A flag register that holds a wrong value shows up directly on `pend`, from the cycle after the edge that corrupted it, and in the next read result one cycle after the read. A bad lane mapping in shared or single-thread mode moves a flag to the wrong bit position, which a read of an asymmetric pattern exposes at once. A gate that decides wrongly shows in two places: `fac_fault` is wrong in the cycle after the access, and the flags on `pend` change or fail to change at the same time. A wrong write-versus-send priority leaves a flag at 1 where the written value was 0, and this is visible on the next cycle.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int MAX_THREADS = 8;

    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_READ    = 2'd1,
        ACC_WRITE   = 2'd2,
        ACC_REFUSED = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic valid;
        logic write;
        logic in_hv;
        logic hv_present;
        logic fac_en;
    } acc_req_t;

    // Hypervisor facility check: refused only for a guest access on a
    // hypervisor-capable core with the enable bit clear.
    function automatic acc_kind_e classify(input acc_req_t r);
        if (!r.valid)
            return ACC_IDLE;
        if (!r.in_hv && r.hv_present && !r.fac_en)
            return ACC_REFUSED;
        return r.write ? ACC_WRITE : ACC_READ;
    endfunction

endpackage

// File: rtl/dbell_gate.sv
module dbell_gate
    import dbell_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  acc_req_t  req,
    output acc_kind_e kind,
    output logic      fault_q,
    output logic      cause_clr_q
);

    assign kind = classify(req);

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q     <= 1'b0;
            cause_clr_q <= 1'b0;
        end else begin
            fault_q     <= (kind == ACC_REFUSED);
            cause_clr_q <= (kind == ACC_REFUSED);
        end
    end

endmodule

// File: rtl/dbell_flags.sv
module dbell_flags #(
    parameter int NTHR = 4,
    parameter int TIDW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            solo,
    input  logic [TIDW-1:0] tid,
    input  logic [NTHR-1:0] wval,
    input  logic [NTHR-1:0] send,
    output logic [NTHR-1:0] flags
);

    logic [NTHR-1:0] lane_sel;
    logic [NTHR-1:0] lane_val;

    for (genvar i = 0; i < NTHR; i++) begin : g_lane
        always_comb begin
            if (solo) begin
                lane_sel[i] = (tid == TIDW'(i));
                lane_val[i] = wval[0];
            end else begin
                lane_sel[i] = 1'b1;
                lane_val[i] = wval[i];
            end
        end

        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (wr_en && lane_sel[i])
                flags[i] <= lane_val[i];
            else if (send[i])
                flags[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/dbell_readout.sv
module dbell_readout #(
    parameter int NTHR = 4,
    parameter int DW   = 32,
    parameter int TIDW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_en,
    input  logic            solo,
    input  logic [TIDW-1:0] tid,
    input  logic [NTHR-1:0] flags,
    output logic [DW-1:0]   data_q,
    output logic            valid_q
);

    logic          own_flag;
    logic [DW-1:0] word;

    always_comb begin
        own_flag = 1'b0;
        for (int i = 0; i < NTHR; i++) begin
            if (tid == TIDW'(i))
                own_flag = flags[i];
        end
        word = '0;
        if (solo)
            word[0] = own_flag;
        else
            word[NTHR-1:0] = flags;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            data_q  <= rd_en ? word : '0;
            valid_q <= rd_en;
        end
    end

endmodule

// File: rtl/dbell_summary.sv
module dbell_summary
    import dbell_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int DW   = 32,
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [DW-1:0]   acc_wdata,
    input  logic            in_hv,
    input  logic            hv_present,
    input  logic            fac_en,
    input  logic            solo_mode,
    input  logic [TIDW-1:0] local_tid,
    input  logic [NTHR-1:0] send_pulse,
    output logic [NTHR-1:0] pend,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid,
    output logic            fac_fault,
    output logic            cause_clr
);

    acc_req_t  req;
    acc_kind_e kind;

    assign req = '{valid:      acc_valid,
                   write:      acc_write,
                   in_hv:      in_hv,
                   hv_present: hv_present,
                   fac_en:     fac_en};

    dbell_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .kind        (kind),
        .fault_q     (fac_fault),
        .cause_clr_q (cause_clr)
    );

    dbell_flags #(.NTHR(NTHR), .TIDW(TIDW)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .wr_en (kind == ACC_WRITE),
        .solo  (solo_mode),
        .tid   (local_tid),
        .wval  (acc_wdata[NTHR-1:0]),
        .send  (send_pulse),
        .flags (pend)
    );

    dbell_readout #(.NTHR(NTHR), .DW(DW), .TIDW(TIDW)) u_read (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (kind == ACC_READ),
        .solo    (solo_mode),
        .tid     (local_tid),
        .flags   (pend),
        .data_q  (rd_data),
        .valid_q (rd_valid)
    );

endmodule

// File: rtl/dbell_summary_chk.sv
module dbell_summary_chk #(
    parameter int NTHR = 4,
    parameter int DW   = 32,
    parameter int TIDW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            acc_valid,
    input logic            acc_write,
    input logic [DW-1:0]   acc_wdata,
    input logic            in_hv,
    input logic            hv_present,
    input logic            fac_en,
    input logic            solo_mode,
    input logic [TIDW-1:0] local_tid,
    input logic [NTHR-1:0] send_pulse,
    input logic [NTHR-1:0] pend,
    input logic [DW-1:0]   rd_data,
    input logic            rd_valid,
    input logic            fac_fault,
    input logic            cause_clr
);

    logic refused;
    logic granted;
    assign refused = acc_valid && !in_hv && hv_present && !fac_en;
    assign granted = acc_valid && !refused;

    // R1: shared-mode read returns the flags from before the access
    p_shared_read_r1: assert property (@(posedge clk) disable iff (rst)
        (granted && !acc_write && !solo_mode)
            |=> (rd_valid && rd_data == DW'($past(pend))));

    // R2: shared-mode write loads every flag
    p_shared_write_r2: assert property (@(posedge clk) disable iff (rst)
        (granted && acc_write && !solo_mode)
            |=> (pend == $past(acc_wdata[NTHR-1:0])));

    // R3: lanes above the thread count never read as 1
    p_high_zero_r3: assert property (@(posedge clk) disable iff (rst)
        ((rd_data >> NTHR) == '0));

    // R4: single-thread read uses bit 0 only
    p_solo_read_r4: assert property (@(posedge clk) disable iff (rst)
        (granted && !acc_write && solo_mode)
            |=> ((rd_data >> 1) == '0));

    // R6: refusal produces the exception pulse
    p_fault_r6: assert property (@(posedge clk) disable iff (rst)
        refused |=> fac_fault);

    p_no_fault_r6: assert property (@(posedge clk) disable iff (rst)
        !refused |=> !fac_fault);

    // R7: a refused access writes nothing and returns nothing
    p_refused_keep_r7: assert property (@(posedge clk) disable iff (rst)
        refused |=> (pend == $past(pend | send_pulse) && !rd_valid && rd_data == '0));

    // R8: cause-field clear goes with the exception
    p_cause_r8: assert property (@(posedge clk) disable iff (rst)
        (fac_fault == cause_clr));

    // R9: send pulses set flags when no access is made
    p_send_r9: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (pend == $past(pend | send_pulse)));

endmodule

bind dbell_summary dbell_summary_chk #(.NTHR(NTHR), .DW(DW), .TIDW(TIDW)) u_chk (.*);

// File: tb/dbell_summary_test.sv
`timescale 1ns/1ps
module dbell_summary_test;

    localparam int NTHR = 4;
    localparam int DW   = 32;
    localparam int TIDW = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            acc_valid = 1'b0;
    logic            acc_write = 1'b0;
    logic [DW-1:0]   acc_wdata = '0;
    logic            in_hv = 1'b1;
    logic            hv_present = 1'b1;
    logic            fac_en = 1'b0;
    logic            solo_mode = 1'b0;
    logic [TIDW-1:0] local_tid = '0;
    logic [NTHR-1:0] send_pulse = '0;
    logic [NTHR-1:0] pend;
    logic [DW-1:0]   rd_data;
    logic            rd_valid;
    logic            fac_fault;
    logic            cause_clr;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    dbell_summary #(.NTHR(NTHR), .DW(DW)) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .in_hv(in_hv), .hv_present(hv_present),
        .fac_en(fac_en), .solo_mode(solo_mode), .local_tid(local_tid),
        .send_pulse(send_pulse), .pend(pend), .rd_data(rd_data),
        .rd_valid(rd_valid), .fac_fault(fac_fault), .cause_clr(cause_clr)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, let the rising edge take it,
    // then return at the next falling edge with inputs back to idle.
    task automatic step(input logic v, input logic w, input logic [DW-1:0] d,
                        input logic [NTHR-1:0] s);
        acc_valid  = v;
        acc_write  = w;
        acc_wdata  = d;
        send_pulse = s;
        @(negedge clk);
        acc_valid  = 1'b0;
        acc_write  = 1'b0;
        send_pulse = '0;
    endtask

    task automatic t_reset;
        check("R10 pend", DW'(pend), '0);
        check("R10 rd_data", rd_data, '0);
        check("R10 rd_valid", DW'(rd_valid), '0);
        check("R10 fac_fault", DW'(fac_fault), '0);
        check("R10 cause_clr", DW'(cause_clr), '0);
    endtask

    task automatic t_shared;
        step(1, 1, 32'hFFFF_FFF5, '0);
        check("R2/R3 write high bits ignored", DW'(pend), 32'h5);
        step(1, 0, '0, '0);
        check("R1 read valid", DW'(rd_valid), 32'h1);
        check("R1/R3 read value", rd_data, 32'h5);
        step(1, 1, 32'h0000_000A, '0);
        check("R2 write clears and sets", DW'(pend), 32'hA);
        step(1, 0, '0, '0);
        check("R1 read second pattern", rd_data, 32'hA);
        step(0, 0, '0, '0);
        check("R1 idle read data", DW'(rd_valid), 32'h0);
    endtask

    task automatic t_solo;
        solo_mode = 1'b1;
        local_tid = 2'd1;
        step(1, 0, '0, '0);
        check("R4 solo read own=1", rd_data, 32'h1);
        local_tid = 2'd0;
        step(1, 0, '0, '0);
        check("R4 solo read own=0", rd_data, 32'h0);
        local_tid = 2'd3;
        step(1, 1, 32'hFFFF_FFFE, '0);
        check("R5 solo write clears own only", DW'(pend), 32'h2);
        local_tid = 2'd0;
        step(1, 1, 32'h0000_0001, '0);
        check("R5 solo write sets own only", DW'(pend), 32'h3);
        solo_mode = 1'b0;
    endtask

    task automatic t_gate;
        in_hv = 1'b0; hv_present = 1'b1; fac_en = 1'b0;
        step(1, 1, 32'h0, '0);
        check("R6 fault pulse", DW'(fac_fault), 32'h1);
        check("R8 cause clear", DW'(cause_clr), 32'h1);
        check("R7 refused write keeps flags", DW'(pend), 32'h3);
        step(1, 0, '0, '0);
        check("R7 refused read valid", DW'(rd_valid), 32'h0);
        check("R7 refused read data", rd_data, 32'h0);
        step(0, 0, '0, '0);
        check("R6 fault is one cycle", DW'(fac_fault), 32'h0);
        check("R8 cause clear one cycle", DW'(cause_clr), 32'h0);
        fac_en = 1'b1;
        step(1, 1, 32'h0, '0);
        check("R6 enable bit allows", DW'(fac_fault), 32'h0);
        check("R6 enabled write lands", DW'(pend), 32'h0);
        fac_en = 1'b0; hv_present = 1'b0;
        step(1, 1, 32'hF, '0);
        check("R6 no hv mode allows", DW'(pend), 32'hF);
        hv_present = 1'b1; in_hv = 1'b1;
        step(1, 1, 32'h0, '0);
        check("R6 hv state allows", DW'(pend), 32'h0);
    endtask

    task automatic t_send;
        step(0, 0, '0, 4'b0100);
        check("R9 send sets flag", DW'(pend), 32'h4);
        step(1, 1, 32'h1, 4'b1111);
        check("R9 write wins over send", DW'(pend), 32'h1);
        solo_mode = 1'b1; local_tid = 2'd0;
        step(1, 1, 32'h0, 4'b1000);
        check("R9/R5 solo write with foreign send", DW'(pend), 32'h8);
        solo_mode = 1'b0;
        in_hv = 1'b0; fac_en = 1'b0;
        step(1, 1, 32'h0, 4'b0001);
        check("R9/R7 send during refused write", DW'(pend), 32'h9);
        in_hv = 1'b1;
    endtask

    initial begin
        #20000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_shared();
        t_solo();
        t_gate();
        t_send();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule